// File: doc/BRIEF.md
# Range Cache-Flush Snoop Sequencer

This block walks a cache over a byte range and asks it to flush every block that the range touches. A single-cycle start pulse supplies a byte address and a byte length. The range is widened to whole blocks: the first block is the address rounded down, and the exclusive end block is address plus length rounded up. The block then offers one snoop request per block index, in ascending order, on a valid/ready channel.

Snoop responses come back on a separate channel. They are counted against the requests that have been accepted. The block raises a one-cycle done flag once every request has been accepted and every response has been received. The response channel is ready for the whole operation. An internal outstanding counter of `CNT_W` bits limits how many requests can be in flight at once. A start pulse that arrives while an operation is running has no effect.

Top module: `flush_range_seq`

## Requirements
- R1: After reset, `snp_req_valid_o`, `snp_rsp_ready_o` and `done_o` are all low.
- R2: The cycle after an accepted start, a non-empty operation presents block index `base_i >> log2(BLK_BYTES)` on `snp_req_idx_o` with valid high. The index is the byte address with its low log2(BLK_BYTES) bits dropped; the default block size is 64 bytes.
- R3: Exactly ceil((base_i+len_i)/BLK_BYTES) - floor(base_i/BLK_BYTES) requests are accepted. Valid is low once they have all been accepted.
- R4: While valid is high and `snp_req_ready_i` is low, valid and the index hold. Each handshake advances the index by exactly one.
- R5: `snp_rsp_ready_o` is high from the cycle after an accepted start up to and including the done cycle, and low otherwise.
- R6: `done_o` is a one-cycle pulse. It is high in the cycle after the last request handshake or response, whichever is later.
- R7: A range whose rounded end index is not greater than its first index issues no request. It raises `done_o` in the cycle after the start.
- R8: A request handshake and a response in the same cycle leave the outstanding count unchanged.
- R9: A response that arrives while nothing is outstanding is ignored. The count does not wrap, and completion still occurs on time.
- R10: A start pulse while an operation is in progress does not alter the index sequence, the request count or the completion timing.
- R11: At most 2^CNT_W - 1 requests (15 by default) are outstanding. Valid stays low while that many are outstanding, even if requests remain to be issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_i | input | ADDR_W | Byte start address |
| len_i | input | ADDR_W | Byte length |
| snp_req_ready_i | input | 1 | Cache accepts a snoop request |
| snp_req_valid_o | output | 1 | Snoop request offered |
| snp_req_idx_o | output | IDX_W | Block index of the offered request |
| snp_rsp_valid_i | input | 1 | Snoop response present |
| snp_rsp_ready_o | output | 1 | Responses accepted (high during an operation) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first request index, and for an empty range the done pulse, appear one cycle after the edge that samples the start. After each handshake the index advances in the next cycle. Done rises one cycle after the last handshake or response, whichever is later. The bench drives inputs at the falling edge and samples outputs at the same falling edge, half a cycle after the edge that produced them. It predicts the due cycle from its own count of handshakes and responses, and compares `done_o` against that prediction to the exact cycle. In every cycle it also checks the expected valid level against its own model of the outstanding count.

// File: rtl/fr_pkg.sv
// Shared types for the range flush sequencer.
// Assumes: nothing beyond a two-state operation.
package fr_pkg;
    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_e;
endpackage

// File: rtl/fr_range.sv
// Converts a byte address and byte length into a first block index and an
// exclusive end block index, rounding the range outward to block borders.
// Assumes: BLK_BYTES is a power of two; EW = ADDR_W - log2(BLK_BYTES) + 2 so
// the end index never wraps, even at the top of the address space.
module fr_range #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int EW        = 28
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic [EW-1:0]     first_o,
    output logic [EW-1:0]     end_o,
    output logic              nonempty_o
);
    localparam int SH    = $clog2(BLK_BYTES);
    localparam int SUM_W = ADDR_W + 2;

    logic [SUM_W-1:0] round_sum;

    // Round-up sum of address, length and one block minus a byte.
    always_comb begin
        round_sum  = {2'b00, base_i} + {2'b00, len_i} + SUM_W'(BLK_BYTES - 1);
        end_o      = EW'(round_sum >> SH);
        first_o    = EW'({2'b00, base_i} >> SH);
        nonempty_o = end_o > first_o;
    end
endmodule

// File: rtl/fr_issue.sv
// Walks the block index from the first to the end index, one per accepted
// request. Valid is withheld while the outstanding counter is full.
// Assumes: load_i only pulses while no walk is running.
module fr_issue #(
    parameter int EW    = 28,
    parameter int IDX_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [EW-1:0]    first_i,
    input  logic [EW-1:0]    end_i,
    input  logic             nonempty_i,
    input  logic             hold_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             active_o,
    output logic             hs_o
);
    logic          active_q;
    logic [EW-1:0] cur_q;
    logic [EW-1:0] end_q;
    logic [EW-1:0] cur_nx;

    // Offer, handshake and next index.
    always_comb begin
        valid_o = active_q && !hold_i;
        hs_o    = valid_o && ready_i;
        cur_nx  = cur_q + 1'b1;
        idx_o   = cur_q[IDX_W-1:0];
        active_o = active_q;
    end

    // Index register: load on start, step on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            end_q    <= '0;
        end else if (load_i) begin
            active_q <= nonempty_i;
            cur_q    <= first_i;
            end_q    <= end_i;
        end else if (hs_o) begin
            cur_q <= cur_nx;
            if (cur_nx >= end_q) begin
                active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fr_outstanding.sv
// Counts snoop requests whose responses have not yet come back.
// Assumes: inc_i never pulses while full_o is high (the issuer holds off).
// A response with nothing outstanding and no issue alongside it is dropped.
module fr_outstanding #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             dec_ok;

    // Status flags and the guarded decrement.
    always_comb begin
        dec_ok = dec_i && ((cnt_q != '0) || inc_i);
        full_o = cnt_q == CNT_MAX;
        zero_o = cnt_q == '0;
        cnt_o  = cnt_q;
    end

    // Count update: an issue and a response together cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc_i, dec_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/flush_range_seq.sv
// Range cache-flush snoop sequencer. A start pulse with a byte address and a
// byte length issues one snoop request per overlapped block and completes
// once all are issued and all responses are back.
// Assumes: the start inputs are valid in the start cycle only; starts are
// ignored while running.
module flush_range_seq #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = ADDR_W - $clog2(BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic              snp_req_ready_i,
    output logic              snp_req_valid_o,
    output logic [IDX_W-1:0]  snp_req_idx_o,
    input  logic              snp_rsp_valid_i,
    output logic              snp_rsp_ready_o,
    output logic              done_o
);
    import fr_pkg::*;

    localparam int EW = IDX_W + 2;

    fr_state_e        state_q;
    logic             load;
    logic             rsp_take;
    logic [EW-1:0]    first_idx;
    logic [EW-1:0]    end_idx;
    logic             nonempty;
    logic             issuing;
    logic             req_hs;
    logic [CNT_W-1:0] out_cnt;
    logic             out_full;
    logic             out_zero;

    fr_range #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .EW(EW)) u_range (
        .base_i     (base_i),
        .len_i      (len_i),
        .first_o    (first_idx),
        .end_o      (end_idx),
        .nonempty_o (nonempty)
    );

    fr_issue #(.EW(EW), .IDX_W(IDX_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .first_i    (first_idx),
        .end_i      (end_idx),
        .nonempty_i (nonempty),
        .hold_i     (out_full),
        .ready_i    (snp_req_ready_i),
        .valid_o    (snp_req_valid_o),
        .idx_o      (snp_req_idx_o),
        .active_o   (issuing),
        .hs_o       (req_hs)
    );

    fr_outstanding #(.CNT_W(CNT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (req_hs),
        .dec_i  (rsp_take),
        .cnt_o  (out_cnt),
        .full_o (out_full),
        .zero_o (out_zero)
    );

    // Start acceptance, response acceptance and completion.
    always_comb begin
        load            = start_i && (state_q == FR_IDLE);
        snp_rsp_ready_o = state_q == FR_RUN;
        rsp_take        = snp_rsp_valid_i && snp_rsp_ready_o;
        done_o          = (state_q == FR_RUN) && !issuing && out_zero;
    end

    // Operation state: idle until started, running until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else if (load) begin
            state_q <= FR_RUN;
        end else if (done_o) begin
            state_q <= FR_IDLE;
        end
    end
endmodule

// File: rtl/fr_checker.sv
// Protocol and counter checks for flush_range_seq, bound to every instance.
// Assumes: connected to the top module's ports and its outstanding count.
module fr_checker #(
    parameter int IDX_W = 26,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDX_W-1:0] req_idx,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             done,
    input logic             issuing,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> (!req_valid && !done));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_idx)));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (req_idx == IDX_W'($past(req_idx) + 1'b1)));

    assert_ready_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> rsp_ready);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_valid && !issuing && cnt == '0));

    assert_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && rsp_valid && rsp_ready) |=> $stable(cnt));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && rsp_valid && rsp_ready && !(req_valid && req_ready)) |=> (cnt == '0));

    assert_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |-> !req_valid);
endmodule

bind flush_range_seq fr_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_fr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (snp_req_valid_o),
    .req_ready (snp_req_ready_i),
    .req_idx   (snp_req_idx_o),
    .rsp_valid (snp_rsp_valid_i),
    .rsp_ready (snp_rsp_ready_o),
    .done      (done_o),
    .issuing   (issuing),
    .cnt       (out_cnt)
);

// File: tb/tb_flush_range_seq.sv
module tb_flush_range_seq;
    localparam int ADDR_W = 32;
    localparam int BLK    = 64;
    localparam int CNT_W  = 4;
    localparam int IDX_W  = ADDR_W - $clog2(BLK);
    localparam int MAXO   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [ADDR_W-1:0] len_i = '0;
    logic              snp_req_ready_i = 1'b0;
    logic              snp_req_valid_o;
    logic [IDX_W-1:0]  snp_req_idx_o;
    logic              snp_rsp_valid_i = 1'b0;
    logic              snp_rsp_ready_o;
    logic              done_o;

    int n_run  = 0;
    int n_fail = 0;
    int max_out = 0;

    always #5 clk = ~clk;

    flush_range_seq #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK), .CNT_W(CNT_W)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .base_i          (base_i),
        .len_i           (len_i),
        .snp_req_ready_i (snp_req_ready_i),
        .snp_req_valid_o (snp_req_valid_o),
        .snp_req_idx_o   (snp_req_idx_o),
        .snp_rsp_valid_i (snp_rsp_valid_i),
        .snp_rsp_ready_o (snp_rsp_ready_o),
        .done_o          (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One flush operation with a ready pattern and a response latency.
    // rmode: 0 always ready, 1 every other cycle, 2 two of three, 3 ready from cycle 5.
    task automatic run_flush(input string name, input logic [31:0] base, input logic [31:0] len,
                             input int rmode, input int lat, input bit spurious, input bit restart);
        longint first = longint'(base) / BLK;
        longint endx  = (longint'(base) + longint'(len) + BLK - 1) / BLK;
        int count = (endx > first) ? int'(endx - first) : 0;
        longint exp_idx = first;
        int issued = 0;
        int resp = 0;
        int last_event = 0;
        int outst;
        bit rdy;
        bit seen = 1'b0;
        int q[$];
        max_out = 0;
        @(negedge clk);
        start_i = 1'b1; base_i = base; len_i = len;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c < 3000; c++) begin
            if (done_o) begin
                seen = 1'b1;
                check(issued == count, "R3", {name, " requests issued"}, issued, count);
                check(resp == count, "R3", {name, " responses seen"}, resp, count);
                if (count == 0)
                    check(c == 1, "R7", {name, " empty-range done cycle"}, c, 1);
                else
                    check(c == last_event + 1, "R6", {name, " done cycle"}, c, last_event + 1);
                snp_req_ready_i = 1'b0;
                snp_rsp_valid_i = 1'b0;
                break;
            end
            check(snp_rsp_ready_o == 1'b1, "R5", {name, " rsp ready while running"}, snp_rsp_ready_o, 1);
            case (rmode)
                1:       rdy = (c % 2) == 1;
                2:       rdy = (c % 3) != 0;
                3:       rdy = c >= 5;
                default: rdy = 1'b1;
            endcase
            snp_req_ready_i = rdy;
            outst = issued - resp;
            check(snp_req_valid_o == ((issued < count) && (outst < MAXO)), "R3/R11",
                  {name, " valid level"}, snp_req_valid_o, (issued < count) && (outst < MAXO));
            if (snp_req_valid_o) begin
                if (issued == 0)
                    check(longint'(snp_req_idx_o) == exp_idx, "R2", {name, " first index"}, snp_req_idx_o, exp_idx);
                else
                    check(longint'(snp_req_idx_o) == exp_idx, "R4", {name, " index"}, snp_req_idx_o, exp_idx);
                if (rdy) begin
                    exp_idx++; issued++; q.push_back(c + lat); last_event = c;
                end
            end
            snp_rsp_valid_i = 1'b0;
            if (spurious && c == 2) begin
                snp_rsp_valid_i = 1'b1;
            end else if (q.size() > 0 && q[0] <= c) begin
                snp_rsp_valid_i = 1'b1;
                void'(q.pop_front());
                resp++; last_event = c;
            end
            if (restart && c == 2) begin
                start_i = 1'b1; base_i = base + 32'h4000; len_i = 32'h40;
            end else begin
                start_i = 1'b0;
            end
            if (issued - resp > max_out) max_out = issued - resp;
            @(negedge clk);
        end
        check(seen, "R6", {name, " completion reached"}, seen, 1);
        @(negedge clk);
        check(done_o == 1'b0, "R6", {name, " done is one cycle"}, done_o, 0);
        check(snp_rsp_ready_o == 1'b0, "R5", {name, " rsp ready low after done"}, snp_rsp_ready_o, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(snp_req_valid_o == 1'b0, "R1", "reset valid", snp_req_valid_o, 0);
        check(snp_rsp_ready_o == 1'b0, "R1", "reset rsp ready", snp_rsp_ready_o, 0);
        check(done_o == 1'b0, "R1", "reset done", done_o, 0);
    endtask

    task automatic t_aligned();    run_flush("aligned R2",   32'h100, 32'h100, 0, 3, 0, 0); endtask
    task automatic t_unaligned();  run_flush("unaligned R4", 32'h13C, 32'h10,  1, 1, 0, 0); endtask
    task automatic t_straddle();   run_flush("straddle R3",  32'h7F,  32'h2,   2, 2, 0, 0); endtask
    task automatic t_empty();      run_flush("empty R7",     32'h80,  32'h0,   0, 2, 0, 0); endtask
    task automatic t_overlap();    run_flush("overlap R8",   32'h0,   32'h200, 0, 1, 0, 0); endtask
    task automatic t_spurious();   run_flush("spurious R9",  32'h400, 32'h80,  3, 2, 1, 0); endtask
    task automatic t_restart();    run_flush("restart R10",  32'h1000, 32'hC0, 0, 4, 0, 1); endtask

    task automatic t_limit();
        run_flush("limit R11", 32'h2000, 32'd1280, 0, 40, 0, 0);
        check(max_out == MAXO, "R11", "peak outstanding", max_out, MAXO);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aligned();
        t_unaligned();
        t_straddle();
        t_empty();
        t_overlap();
        t_spurious();
        t_restart();
        t_limit();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule